// File: doc/BRIEF.md
# I/O Page-Table Address Translator

This block translates the addresses of DMA accesses started by PCI devices into system addresses. It accepts one request at a time over a valid/ready handshake and sorts it by address. An address that fits in 32 bits passes through unchanged on a fixed default path. A wider address is compared with a programmable base/mask window that has its own enable bit. Outside the window, or with the window disabled, the address comes back marked untranslated.

Inside the window the page number of the address indexes a directory in memory. The block issues one 64-bit read for the entry and waits for the read data. The top bit of the entry marks it valid. A valid entry supplies the physical page number, which is joined with the 12-bit page offset of the request. An invalid entry gives a no-permission fault.

Four 64-bit configuration registers are written and read through a small select port: window base, window mask, directory base, and a purge command. The purge command is stored and can be read back, but it has no effect on translation.

Top module: `iopt_xlate`

## Requirements
- R1: After reset all four configuration registers read zero, `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0.
- R2: A request whose address has bits 63:32 all zero gets a response one cycle after acceptance with `rsp_kind` = 0 (default path) and `rsp_addr` equal to the request address. No memory read is issued.
- R3: If bit 0 of the window base register is 0, a request above 32 bits gets `rsp_kind` = 1 (untranslated), its own address, and no memory read, one cycle after acceptance.
- R4: If `(addr & mask)` differs from the window base with bit 0 forced to 0, the request gets `rsp_kind` = 1, its own address, and no memory read.
- R5: A request inside an enabled window raises `mem_rd_req` for exactly one cycle, the cycle after acceptance. `mem_rd_addr` = directory base + (addr >> 12) * 8. The entry is read as a little-endian 64-bit word, with the byte at the lowest address in bits 7:0.
- R6: An entry with bit 63 set gives `rsp_kind` = 2 (translated) in the cycle after `mem_rd_valid`. `rsp_addr` has bit 63 = 0, bits 62:12 from the entry, and bits 11:0 from the request.
- R7: An entry with bit 63 clear gives `rsp_kind` = 3 (fault) and `rsp_addr` = 0 in the cycle after `mem_rd_valid`.
- R8: A value written to the purge register is held and read back, and it does not change any translation result.
- R9: Only one request is in flight. `req_ready` is 0 from the cycle after acceptance through the cycle with `rsp_valid`, which lasts one cycle, and it returns to 1 in the next cycle.
- R10: A configuration write in the same cycle as a request acceptance does not affect that request. It applies to the next request.
- R11: `cfg_sel` selects a register: 0 window base, 1 window mask, 2 directory base, 3 purge. `cfg_rdata` shows the selected register without delay, and a write stores `cfg_wdata` into the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 mask, 2 directory, 3 purge) |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Selected register contents |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle and able to accept |
| req_addr | input | 64 | I/O address to translate |
| mem_rd_req | output | 1 | One-cycle directory read request |
| mem_rd_addr | output | 64 | Directory entry address |
| mem_rd_valid | input | 1 | Directory read data valid |
| mem_rd_data | input | 64 | Directory entry |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_kind | output | 2 | 0 default path, 1 untranslated, 2 translated, 3 fault |
| rsp_addr | output | 64 | Resulting address (0 on fault) |

## Verification
A configuration write can land in the same cycle that a request is accepted, and a careless design would let the new register value steer that request. The bench drives a request and a write that disables the window in the same cycle. It then checks that the request still walks the directory with the old settings and that the next request with the same address comes back untranslated. The table-driven part covers every route, including the 32-bit boundary and read-data delays of different lengths, and the bench computes each expected result from the requirements.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    localparam int CFG_SEL_W = 2;

    localparam logic [CFG_SEL_W-1:0] SEL_BASE  = 2'd0;
    localparam logic [CFG_SEL_W-1:0] SEL_MASK  = 2'd1;
    localparam logic [CFG_SEL_W-1:0] SEL_DIR   = 2'd2;
    localparam logic [CFG_SEL_W-1:0] SEL_PURGE = 2'd3;

    typedef enum logic [1:0] {
        KIND_DIRECT = 2'd0,
        KIND_PASS   = 2'd1,
        KIND_XLATE  = 2'd2,
        KIND_FAULT  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ROUTE_DIRECT = 2'd0,
        ROUTE_PASS   = 2'd1,
        ROUTE_WALK   = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;

endpackage

// File: rtl/iopt_cfg_regs.sv
module iopt_cfg_regs
    import iopt_pkg::*;
#(
    parameter int W    = 64,
    parameter int NREG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_SEL_W-1:0] sel,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         rdata,
    output logic [W-1:0]         win_base,
    output logic [W-1:0]         win_mask,
    output logic [W-1:0]         dir_base
);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[sel] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata    = regs_q[sel];
    assign win_base = regs_q[SEL_BASE];
    assign win_mask = regs_q[SEL_MASK];
    assign dir_base = regs_q[SEL_DIR];

    // R11: a write lands in the selected register
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(sel)] == $past(wdata));

    // R8: the purge register changes only when it is written
    assert_purge_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_PURGE) |=> $stable(regs_q[SEL_PURGE]));

endmodule

// File: rtl/iopt_range_check.sv
module iopt_range_check
    import iopt_pkg::*;
#(
    parameter int W          = 64,
    parameter int DIRECT_W   = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_W    = 64
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] win_base,
    input  logic [W-1:0] win_mask,
    input  logic [W-1:0] dir_base,
    output route_e       route,
    output logic [W-1:0] fetch_addr
);

    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);
    localparam logic [W-1:0] EN_BIT = W'(1);

    logic narrow;
    logic win_on;
    logic in_win;

    always_comb begin
        narrow     = (addr >> DIRECT_W) == '0;
        win_on     = (win_base & EN_BIT) != '0;
        in_win     = (addr & win_mask) == (win_base & ~EN_BIT);
        fetch_addr = dir_base + ((addr >> PAGE_SHIFT) << ENTRY_SHIFT);
        if (narrow) begin
            route = ROUTE_DIRECT;
        end else if (win_on && in_win) begin
            route = ROUTE_WALK;
        end else begin
            route = ROUTE_PASS;
        end
    end

endmodule

// File: rtl/iopt_walk_fsm.sv
module iopt_walk_fsm
    import iopt_pkg::*;
#(
    parameter int W          = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] req_addr,
    input  route_e       route,
    input  logic [W-1:0] fetch_addr,
    output logic         req_ready,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_rvalid,
    input  logic [W-1:0] mem_rdata,
    output logic         rsp_valid,
    output kind_e        rsp_kind,
    output logic [W-1:0] rsp_addr
);

    localparam logic [W-1:0] OFS_MASK   = (W'(1) << PAGE_SHIFT) - W'(1);
    localparam logic [W-1:0] VALID_MASK = W'(1) << (W - 1);

    typedef struct packed {
        walk_st_e     st;
        logic [W-1:0] addr;
        logic [W-1:0] fetch;
        logic [W-1:0] out;
        kind_e        kind;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic fire;

    assign fire = req_valid && (ctx_q.st == ST_IDLE);

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (fire) begin
                    ctx_d.addr  = req_addr;
                    ctx_d.fetch = fetch_addr;
                    ctx_d.out   = req_addr;
                    unique case (route)
                        ROUTE_DIRECT: begin
                            ctx_d.kind = KIND_DIRECT;
                            ctx_d.st   = ST_RESP;
                        end
                        ROUTE_WALK: begin
                            ctx_d.st = ST_ISSUE;
                        end
                        default: begin
                            ctx_d.kind = KIND_PASS;
                            ctx_d.st   = ST_RESP;
                        end
                    endcase
                end
            end
            ST_ISSUE: begin
                ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    ctx_d.st = ST_RESP;
                    if ((mem_rdata & VALID_MASK) != '0) begin
                        ctx_d.kind = KIND_XLATE;
                        ctx_d.out  = (mem_rdata & ~(VALID_MASK | OFS_MASK))
                                   | (ctx_q.addr & OFS_MASK);
                    end else begin
                        ctx_d.kind = KIND_FAULT;
                        ctx_d.out  = '0;
                    end
                end
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, kind: KIND_DIRECT, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready = (ctx_q.st == ST_IDLE);
    assign mem_req   = (ctx_q.st == ST_ISSUE);
    assign mem_addr  = ctx_q.fetch;
    assign rsp_valid = (ctx_q.st == ST_RESP);
    assign rsp_kind  = ctx_q.kind;
    assign rsp_addr  = ctx_q.out;

    // R5: a walk issues its read the cycle after acceptance, at the computed address
    assert_fetch_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && route == ROUTE_WALK) |=> mem_req && mem_addr == $past(fetch_addr));

    // R5: exactly one read cycle per walk
    assert_single_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R6: a valid entry gives a translated response with its page number
    assert_xlate_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_WAIT && mem_rvalid && mem_rdata[W-1])
        |=> rsp_valid && rsp_kind == KIND_XLATE && !rsp_addr[W-1]
            && rsp_addr[W-2:PAGE_SHIFT] == $past(mem_rdata[W-2:PAGE_SHIFT]));

    // R7: an invalid entry gives a fault with a zero address
    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_WAIT && mem_rvalid && !mem_rdata[W-1])
        |=> rsp_valid && rsp_kind == KIND_FAULT && rsp_addr == '0);

    // R9: no second acceptance while busy
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: the response lasts one cycle and is followed by readiness
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready && !rsp_valid);

    // R9: a read and a response never share a cycle
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && rsp_valid));

endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DIRECT_W   = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 mem_rd_req,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [ADDR_W-1:0]    mem_rd_data,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_kind,
    output logic [ADDR_W-1:0]    rsp_addr
);

    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] dir_base;
    logic [ADDR_W-1:0] fetch_addr;
    route_e            route;
    kind_e             kind;

    iopt_cfg_regs #(.W(ADDR_W), .NREG(4)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .win_base (win_base),
        .win_mask (win_mask),
        .dir_base (dir_base)
    );

    iopt_range_check #(
        .W(ADDR_W), .DIRECT_W(DIRECT_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_W(ADDR_W)
    ) i_range (
        .addr       (req_addr),
        .win_base   (win_base),
        .win_mask   (win_mask),
        .dir_base   (dir_base),
        .route      (route),
        .fetch_addr (fetch_addr)
    );

    iopt_walk_fsm #(.W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) i_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .route      (route),
        .fetch_addr (fetch_addr),
        .req_ready  (req_ready),
        .mem_req    (mem_rd_req),
        .mem_addr   (mem_rd_addr),
        .mem_rvalid (mem_rd_valid),
        .mem_rdata  (mem_rd_data),
        .rsp_valid  (rsp_valid),
        .rsp_kind   (kind),
        .rsp_addr   (rsp_addr)
    );

    assign rsp_kind = kind;

    // R2: narrow addresses come back unchanged on the default path one cycle later
    assert_direct_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr >> DIRECT_W) == '0)
        |=> rsp_valid && rsp_kind == 2'd0 && rsp_addr == $past(req_addr) && !mem_rd_req);

    // R3: a disabled window never reads memory
    assert_disabled_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !win_base[0]) |=> !mem_rd_req);

endmodule

// File: tb/test_iopt_xlate.sv
module test_iopt_xlate;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] addr;
        logic [63:0] base;
        logic [63:0] mask;
        logic [63:0] dir;
        logic [63:0] purge;
        logic [3:0]  dly;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_1234_5678, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'h0, 4'd0},
        '{64'h0000_0000_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 64'h0, 4'd0},
        '{64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, 64'h0, 4'd0},
        '{64'h0000_0002_0000_4ABC, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, 64'h0, 4'd0},
        '{64'h0000_0001_0003_5123, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, 64'h0, 4'd0},
        '{64'h0000_0001_0000_0ABC, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, 64'hDEAD_BEEF, 4'd3},
        '{64'h0000_0001_0000_2FFF, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h4000_0000, 64'h0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [63:0] rsp_addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iopt_xlate i_iopt_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_kind     (rsp_kind),
        .rsp_addr     (rsp_addr)
    );

    function automatic logic [63:0] mem_model(input logic [63:0] a);
        return {~a[4], 11'h0, a[51:0] ^ 52'h5A5A5C3C30F0F};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        cfg_sel = s;
        #1 d = cfg_rdata;
    endtask

    task automatic expect_fn(input logic [63:0] a, input logic [63:0] b, input logic [63:0] m,
                             input logic [63:0] d, input int dly,
                             output logic [1:0] k, output logic [63:0] o, output logic [63:0] f,
                             output int n, output int lat);
        logic [63:0] e;
        f = '0; n = 0; lat = 1; o = a;
        if (a[63:32] == 32'h0) begin
            k = 2'd0;
        end else if (!b[0] || ((a & m) != (b & ~64'd1))) begin
            k = 2'd1;
        end else begin
            f = d + ((a >> 12) << 3);
            e = mem_model(f);
            n = 1;
            lat = 3 + dly;
            if (e[63]) begin
                k = 2'd2;
                o = {1'b0, e[62:12], a[11:0]};
            end else begin
                k = 2'd3;
                o = '0;
            end
        end
    endtask

    task automatic run_req(input logic [63:0] a, input int dly, input bit cw,
                           input logic [1:0] cs, input logic [63:0] cd,
                           output logic [1:0] k, output logic [63:0] o, output logic [63:0] f,
                           output int n, output int lat, output bit bad);
        int  cnt;
        bit  pend;
        bit  done;
        k = 2'd0; o = '0; f = '0; n = 0; lat = 0; bad = 1'b0;
        cnt = 0; pend = 1'b0; done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        if (cw) begin
            cfg_we = 1'b1; cfg_sel = cs; cfg_wdata = cd;
        end
        while (!done) begin
            @(negedge clk);
            req_valid = 1'b0; cfg_we = 1'b0; mem_rd_valid = 1'b0;
            lat++;
            if (req_ready) bad = 1'b1;
            if (rsp_valid) begin
                k = rsp_kind; o = rsp_addr; done = 1'b1;
            end else if (mem_rd_req) begin
                n++; f = mem_rd_addr; cnt = dly; pend = 1'b1;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rd_valid = 1'b1; mem_rd_data = mem_model(f); pend = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (lat > 100) begin
                done = 1'b1; bad = 1'b1;
            end
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k, input logic [63:0] b);
        if (k == 2'd0) return "R2";
        if (k == 2'd1 && !b[0]) return "R3";
        if (k == 2'd1) return "R4";
        if (k == 2'd2) return "R6";
        return "R7";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0]  ek, ak;
        logic [63:0] eo, ao, ef, af, rd;
        int          en, an, elat, alat;
        bit          bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0 && mem_rd_req === 1'b0, "R1 idle outputs",
            64'({rsp_valid, mem_rd_req}), 64'd0);
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), rd);
            chk(rd === 64'h0, "R1 register zero", rd, 64'h0);
        end

        // R11: select codes map to distinct registers
        for (int s = 0; s < 4; s++) cfg_write(2'(s), 64'h1111_0000_0000_0000 * (s + 1) + 64'(s));
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), rd);
            chk(rd === 64'h1111_0000_0000_0000 * (s + 1) + 64'(s), "R11 readback",
                rd, 64'h1111_0000_0000_0000 * (s + 1) + 64'(s));
        end

        // Table of vectors
        for (int i = 0; i < NVEC; i++) begin
            cfg_write(2'd0, VECS[i].base);
            cfg_write(2'd1, VECS[i].mask);
            cfg_write(2'd2, VECS[i].dir);
            cfg_write(2'd3, VECS[i].purge);
            expect_fn(VECS[i].addr, VECS[i].base, VECS[i].mask, VECS[i].dir, int'(VECS[i].dly),
                      ek, eo, ef, en, elat);
            run_req(VECS[i].addr, int'(VECS[i].dly), 1'b0, 2'd0, 64'h0, ak, ao, af, an, alat, bad);
            chk(ak === ek, kind_tag(ek, VECS[i].base), 64'(ak), 64'(ek));
            chk(ao === eo, kind_tag(ek, VECS[i].base), ao, eo);
            chk(an == en, "R5 read count", 64'(an), 64'(en));
            if (en == 1) chk(af === ef, "R5 fetch address", af, ef);
            chk(alat == elat, "R9 latency", 64'(alat), 64'(elat));
            chk(!bad, "R9 busy while in flight", 64'(bad), 64'd0);
            @(negedge clk);
            chk(req_ready === 1'b1, "R9 ready after response", 64'(req_ready), 64'd1);
        end

        // R8: purge value held, translation unchanged
        cfg_read(2'd3, rd);
        chk(rd === 64'h0, "R8 purge holds last write", rd, 64'h0);
        cfg_write(2'd0, 64'h0000_0001_0000_0001);
        cfg_write(2'd1, 64'hFFFF_FFFF_0000_0000);
        cfg_write(2'd2, 64'h8000_0000);
        cfg_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_fn(64'h0000_0001_0003_5123, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000,
                  64'h8000_0000, 1, ek, eo, ef, en, elat);
        run_req(64'h0000_0001_0003_5123, 1, 1'b0, 2'd0, 64'h0, ak, ao, af, an, alat, bad);
        chk(ak === ek && ao === eo, "R8 purge no effect", ao, eo);
        cfg_read(2'd3, rd);
        chk(rd === 64'hFFFF_FFFF_FFFF_FFFF, "R8 purge readback", rd, 64'hFFFF_FFFF_FFFF_FFFF);

        // R10: write disabling window in the acceptance cycle
        run_req(64'h0000_0001_0000_0ABC, 0, 1'b1, 2'd0, 64'h0000_0001_0000_0000,
                ak, ao, af, an, alat, bad);
        chk(an == 1, "R10 accepted request keeps old window", 64'(an), 64'd1);
        chk(ak === 2'd2, "R10 old settings translate", 64'(ak), 64'd2);
        run_req(64'h0000_0001_0000_0ABC, 0, 1'b0, 2'd0, 64'h0, ak, ao, af, an, alat, bad);
        chk(ak === 2'd1 && an == 0, "R10 new settings apply next", 64'(ak), 64'd1);
        chk(ao === 64'h0000_0001_0000_0ABC, "R3 disabled passes address", ao, 64'h0000_0001_0000_0ABC);

        // R10: directory base write in the acceptance cycle
        cfg_write(2'd0, 64'h0000_0001_0000_0001);
        expect_fn(64'h0000_0001_0000_2FFF, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000,
                  64'h8000_0000, 0, ek, eo, ef, en, elat);
        run_req(64'h0000_0001_0000_2FFF, 0, 1'b1, 2'd2, 64'h1234_0000,
                ak, ao, af, an, alat, bad);
        chk(af === ef, "R10 fetch uses old directory", af, ef);
        chk(ak === ek, "R7 fault kind", 64'(ak), 64'(ek));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule